// File: doc/BRIEF.md
# Knee-Curve Brightness to PWM Count Mapper

This block turns a requested brightness level into the number of clock counts that a PWM output stays high. The level first goes through a two-segment linear remap: a configurable knee level is moved onto a configurable target, and the segments below and above the knee are stretched or squeezed to match. The remapped level is then scaled linearly into a window of PWM counts. The block also reports the duty that this count represents, rounded on either a 0 to 100 or a 0 to 255 scale.

A request is a one-cycle `start` pulse. At that edge the block captures the level and all configuration inputs. It then works through six divisions on one shared restoring divider, which yields one quotient bit per cycle. When it finishes it updates `hiCount` and `duty` and pulses `done`. All arithmetic is unsigned at `DW` bits, and products are truncated to `DW` bits. Any division by zero yields a quotient of zero.

Top module: `blevel_mapper`

## Requirements
- R1: When the knee level equals its target (`cfgLvlMid == cfgMidTarget`), the level and both configured endpoints pass through the remap unchanged, with no clamping.
- R2: With the remap active, a level above `cfgLvlMax` is treated as `cfgLvlMax`.
- R3: With the remap active, a level L with mid <= L <= max maps to (L-mid)*(max-target)/(max-mid) + target, using truncating division.
- R4: With the remap active, a level L with min <= L < mid maps to (L-min)*(target-min)/(mid-min) + min.
- R5: With the remap active, a level below `cfgLvlMin` maps to 0.
- R6: The configured max and min levels go through the same remap, and the remapped values are the scaling endpoints Mmax and Mmin.
- R7: `hiCount` = `cfgCntMin` when Mmax <= Mmin or when the remapped level Lm < Mmin. Otherwise `hiCount` = cfgCntMin + (cfgCntMax-cfgCntMin)*(Lm-Mmin)/(Mmax-Mmin).
- R8: `duty` = (hiCount*K/cfgPeriod + 5)/10, where K = 2550 when `dutyScale8` is 1 (0 to 255 scale) and K = 1000 when it is 0 (percent scale).
- R9: A zero divisor gives a zero quotient. For example, cfgPeriod = 0 gives duty 0, and a knee equal to max maps max onto the target.
- R10: A `start` that arrives while a request is in progress is ignored and does not change that request's results.
- R11: `done` is high for exactly one cycle, on the 205th rising edge counting the edge that samples `start` as the first (6*(DW+2)+1 for DW=32). The outputs change only together with `done` and hold until the next request.
- R12: After reset, `hiCount`, `duty` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request strobe |
| level | input | DW | Requested brightness level |
| cfgLvlMin | input | DW | Lowest usable level |
| cfgLvlMid | input | DW | Knee level |
| cfgLvlMax | input | DW | Highest level |
| cfgMidTarget | input | DW | Value the knee is moved onto |
| cfgCntMin | input | DW | PWM count at the bottom of the window |
| cfgCntMax | input | DW | PWM count at the top of the window |
| cfgPeriod | input | DW | PWM period in counts |
| dutyScale8 | input | 1 | 1: duty on 0..255, 0: duty in percent |
| hiCount | output | DW | Resulting PWM high-time count |
| duty | output | DW | Rounded duty value |
| done | output | 1 | One-cycle result strobe |

## Verification
Every result is due at one fixed point: the latency does not depend on the data, and all six divisions always run. The bench drives `start` on a falling edge and counts rising edges until `done` reads high on a falling edge. It expects 205, and it then compares both outputs against an arithmetic model of the remap, scaling and duty rounding. One edge later it checks that `done` has dropped and that the outputs held. For the busy case it injects a second `start` five edges into a request and checks that the first request's results and latency are unchanged.

// File: rtl/blm_pkg.sv
package blm_pkg;

  // Order of the division passes; each pass uses the results of earlier ones.
  typedef enum logic [2:0] {
    ST_LEVEL   = 3'd0,
    ST_TOP     = 3'd1,
    ST_BOTTOM  = 3'd2,
    ST_SCALE   = 3'd3,
    ST_DUTYMUL = 3'd4,
    ST_DUTYRND = 3'd5
  } step_e;

  localparam int unsigned NSTEPS = 6;

  typedef struct packed {
    logic  load;     // capture request inputs
    logic  launch;   // start a division
    logic  capture;  // store the division result for this step
    step_e step;
  } ctrl_t;

endpackage

// File: rtl/blm_divider.sv
module blm_divider #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] numer,
  input  logic [DW-1:0] denom,
  output logic          fin,
  output logic [DW-1:0] quot
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] remR, quoR, dvsR;
  logic [CW-1:0] cntR;
  logic          runR, zeroR;
  logic [DW:0]   shifted;
  logic          fits;

  assign shifted = {remR, quoR[DW-1]};
  assign fits    = shifted >= {1'b0, dvsR};
  assign quot    = zeroR ? '0 : quoR;

  always_ff @(posedge clk) begin
    if (rst) begin
      remR  <= '0;
      quoR  <= '0;
      dvsR  <= '0;
      cntR  <= '0;
      runR  <= 1'b0;
      zeroR <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        remR  <= '0;
        quoR  <= numer;
        dvsR  <= denom;
        zeroR <= (denom == '0);
        cntR  <= CW'(DW);
        runR  <= 1'b1;
      end else if (runR) begin
        remR <= fits ? DW'(shifted - {1'b0, dvsR}) : shifted[DW-1:0];
        quoR <= {quoR[DW-2:0], fits};
        cntR <= cntR - 1'b1;
        if (cntR == CW'(1)) begin
          runR <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/blm_control.sv
module blm_control
  import blm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  divFin,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e stateR;
  step_e  stepR;
  logic   lastStep;

  assign lastStep     = (stepR == ST_DUTYRND);
  assign busy         = (stateR != S_IDLE);
  assign ctrl.load    = (stateR == S_IDLE) && start;
  assign ctrl.launch  = (stateR == S_ISSUE);
  assign ctrl.capture = (stateR == S_WAIT) && divFin;
  assign ctrl.step    = stepR;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateR <= S_IDLE;
      stepR  <= ST_LEVEL;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (stateR)
        S_IDLE: if (start) begin
          stateR <= S_ISSUE;
          stepR  <= ST_LEVEL;
        end
        S_ISSUE: stateR <= S_WAIT;
        S_WAIT: if (divFin) begin
          if (lastStep) begin
            stateR <= S_IDLE;
            done   <= 1'b1;
          end else begin
            stateR <= S_ISSUE;
            stepR  <= step_e'(stepR + 3'd1);
          end
        end
        default: stateR <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blm_datapath.sv
module blm_datapath
  import blm_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] level,
  input  logic [DW-1:0] cfgLvlMin,
  input  logic [DW-1:0] cfgLvlMid,
  input  logic [DW-1:0] cfgLvlMax,
  input  logic [DW-1:0] cfgMidTarget,
  input  logic [DW-1:0] cfgCntMin,
  input  logic [DW-1:0] cfgCntMax,
  input  logic [DW-1:0] cfgPeriod,
  input  logic          dutyScale8,
  input  logic [DW-1:0] divQuot,
  output logic [DW-1:0] divNumer,
  output logic [DW-1:0] divDenom,
  output logic [DW-1:0] hiCount,
  output logic [DW-1:0] duty
);
  logic [DW-1:0] rLvl, rMin, rMid, rMax, rTgt, rCMin, rCMax, rPer;
  logic          rWide;
  logic [DW-1:0] mLvl, mMax, mMin, cntW, dutyTmp;
  logic [DW-1:0] xSel, xClamp, remapOut, cntOut, kScale;
  logic          passThru, upper, inRange, degenerate;

  always_comb begin
    unique case (ctrl.step)
      ST_TOP:    xSel = rMax;
      ST_BOTTOM: xSel = rMin;
      default:   xSel = rLvl;
    endcase
  end

  assign xClamp     = (xSel > rMax) ? rMax : xSel;
  assign passThru   = (rMid == rTgt);
  assign upper      = (xClamp >= rMid);
  assign inRange    = (xClamp >= rMin);
  assign kScale     = rWide ? DW'(2550) : DW'(1000);
  assign degenerate = (mMax <= mMin) || (mLvl < mMin);

  always_comb begin
    unique case (ctrl.step)
      ST_SCALE: begin
        divNumer = DW'((rCMax - rCMin) * (mLvl - mMin));
        divDenom = mMax - mMin;
      end
      ST_DUTYMUL: begin
        divNumer = DW'(cntW * kScale);
        divDenom = rPer;
      end
      ST_DUTYRND: begin
        divNumer = dutyTmp + DW'(5);
        divDenom = DW'(10);
      end
      default: begin
        divNumer = upper ? DW'((xClamp - rMid) * (rMax - rTgt))
                         : DW'((xClamp - rMin) * (rTgt - rMin));
        divDenom = upper ? (rMax - rMid) : (rMid - rMin);
      end
    endcase
  end

  assign remapOut = passThru ? xSel
                  : upper    ? divQuot + rTgt
                  : inRange  ? divQuot + rMin
                  : '0;
  assign cntOut   = degenerate ? rCMin : rCMin + divQuot;

  always_ff @(posedge clk) begin
    if (rst) begin
      {rLvl, rMin, rMid, rMax, rTgt, rCMin, rCMax, rPer} <= '0;
      rWide   <= 1'b0;
      {mLvl, mMax, mMin, cntW, dutyTmp} <= '0;
      hiCount <= '0;
      duty    <= '0;
    end else if (ctrl.load) begin
      rLvl  <= level;
      rMin  <= cfgLvlMin;
      rMid  <= cfgLvlMid;
      rMax  <= cfgLvlMax;
      rTgt  <= cfgMidTarget;
      rCMin <= cfgCntMin;
      rCMax <= cfgCntMax;
      rPer  <= cfgPeriod;
      rWide <= dutyScale8;
    end else if (ctrl.capture) begin
      unique case (ctrl.step)
        ST_LEVEL:   mLvl    <= remapOut;
        ST_TOP:     mMax    <= remapOut;
        ST_BOTTOM:  mMin    <= remapOut;
        ST_SCALE:   cntW    <= cntOut;
        ST_DUTYMUL: dutyTmp <= divQuot;
        default: begin
          duty    <= divQuot;
          hiCount <= cntW;
        end
      endcase
    end
  end
endmodule

// File: rtl/blevel_mapper.sv
module blevel_mapper
  import blm_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] level,
  input  logic [DW-1:0] cfgLvlMin,
  input  logic [DW-1:0] cfgLvlMid,
  input  logic [DW-1:0] cfgLvlMax,
  input  logic [DW-1:0] cfgMidTarget,
  input  logic [DW-1:0] cfgCntMin,
  input  logic [DW-1:0] cfgCntMax,
  input  logic [DW-1:0] cfgPeriod,
  input  logic          dutyScale8,
  output logic [DW-1:0] hiCount,
  output logic [DW-1:0] duty,
  output logic          done
);
  ctrl_t         ctrl;
  logic          busy, divFin;
  logic [DW-1:0] divNumer, divDenom, divQuot;

  blm_control ctrlI (
    .clk(clk), .rst(rst), .start(start), .divFin(divFin),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  blm_divider #(.DW(DW)) divI (
    .clk(clk), .rst(rst), .go(ctrl.launch), .numer(divNumer),
    .denom(divDenom), .fin(divFin), .quot(divQuot)
  );

  blm_datapath #(.DW(DW)) dpI (
    .clk(clk), .rst(rst), .ctrl(ctrl), .level(level),
    .cfgLvlMin(cfgLvlMin), .cfgLvlMid(cfgLvlMid), .cfgLvlMax(cfgLvlMax),
    .cfgMidTarget(cfgMidTarget), .cfgCntMin(cfgCntMin),
    .cfgCntMax(cfgCntMax), .cfgPeriod(cfgPeriod), .dutyScale8(dutyScale8),
    .divQuot(divQuot), .divNumer(divNumer), .divDenom(divDenom),
    .hiCount(hiCount), .duty(duty)
  );
endmodule

// File: rtl/blm_checker.sv
module blm_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] hiCount,
  input logic [DW-1:0] duty
);
  localparam int unsigned LAT = blm_pkg::NSTEPS * (DW + 2);
  localparam int unsigned RCW = $clog2(LAT + 2);

  logic [RCW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst)       runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(hiCount) || !$stable(duty)) |-> done);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (runCnt == RCW'(LAT)));
endmodule

bind blevel_mapper blm_checker #(.DW(DW)) chkI (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .hiCount(hiCount), .duty(duty)
);

// File: tb/blevel_mapper_tb_top.sv
module blevel_mapper_tb_top;
  localparam int unsigned DW = 32;
  localparam int EXP_EDGES = 6 * (DW + 2) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DW-1:0] level = '0, cLo = '0, cMid = '0, cHi = '0, cTgt = '0;
  logic [DW-1:0] cCMin = '0, cCMax = '0, cPer = '0;
  logic wide = 1'b0;
  logic [DW-1:0] hiCount, duty;
  logic done;
  int total = 0, bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  blevel_mapper #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .level(level),
    .cfgLvlMin(cLo), .cfgLvlMid(cMid), .cfgLvlMax(cHi), .cfgMidTarget(cTgt),
    .cfgCntMin(cCMin), .cfgCntMax(cCMax), .cfgPeriod(cPer),
    .dutyScale8(wide), .hiCount(hiCount), .duty(duty), .done(done)
  );

  function automatic logic [31:0] qdiv(logic [31:0] a, logic [31:0] b);
    return (b == 0) ? 32'd0 : a / b;
  endfunction

  function automatic logic [31:0] remapM(logic [31:0] x);
    logic [31:0] v;
    if (cMid == cTgt) return x;
    v = (x > cHi) ? cHi : x;
    if (v >= cMid) return qdiv((v - cMid) * (cHi - cTgt), cHi - cMid) + cTgt;
    if (v >= cLo) return qdiv((v - cLo) * (cTgt - cLo), cMid - cLo) + cLo;
    return 32'd0;
  endfunction

  function automatic logic [31:0] expCount(logic [31:0] lv);
    logic [31:0] ml, mx, mn;
    ml = remapM(lv); mx = remapM(cHi); mn = remapM(cLo);
    if (mx <= mn || ml < mn) return cCMin;
    return cCMin + qdiv((cCMax - cCMin) * (ml - mn), mx - mn);
  endfunction

  function automatic logic [31:0] expDuty(logic [31:0] cnt);
    logic [31:0] k;
    k = wide ? 32'd2550 : 32'd1000;
    return qdiv(qdiv(cnt * k, cPer) + 32'd5, 32'd10);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(int lo, int md, int hi, int tg, int cmn, int cmx, int per, bit w);
    @(negedge clk);
    cLo = lo; cMid = md; cHi = hi; cTgt = tg;
    cCMin = cmn; cCMax = cmx; cPer = per; wide = w;
  endtask

  // One request; optional second start injected while busy (R10).
  task automatic runOne(int lv, string req, bit inject);
    int n;
    logic [31:0] ec, ed, hc, hd;
    ec = expCount(lv);
    ed = expDuty(ec);
    @(negedge clk);
    start = 1'b1;
    level = lv;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (inject && n == 5) begin
        start = 1'b1;
        level = lv + 37;
      end else begin
        start = 1'b0;
      end
    end while (!done && n < 400);
    chk("R11 latency", n, EXP_EDGES);
    chk(req, hiCount, ec);
    chk(inject ? "R10 duty" : "R8 duty", duty, ed);
    hc = hiCount;
    hd = duty;
    @(posedge clk);
    @(negedge clk);
    chk("R11 done low", {31'd0, done}, 32'd0);
    chk("R11 hold", hiCount, hc);
    chk("R11 hold duty", duty, hd);
  endtask

  function automatic string regionTag(int lv);
    if (cMid == cTgt) return "R1 passthrough";
    if (lv > cHi) return "R2 clamp";
    if (lv >= cMid) return "R3 upper";
    if (lv >= cLo) return "R4 lower";
    return "R5 below min";
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12
    chk("R12 count", hiCount, 0);
    chk("R12 duty", duty, 0);
    chk("R12 done", {31'd0, done}, 0);

    // Knee active, percent scale: every level 0..255
    setCfg(10, 50, 200, 100, 40, 900, 1000, 1'b0);
    for (int lv = 0; lv < 256; lv++) runOne(lv, regionTag(lv), 1'b0);

    // Passthrough, 8-bit duty scale (R1, R8)
    setCfg(20, 90, 180, 90, 100, 3000, 4000, 1'b1);
    for (int lv = 0; lv < 256; lv += 3) runOne(lv, regionTag(lv), 1'b0);

    // Knee at max: endpoint remapped via zero divisor (R6, R9)
    setCfg(0, 100, 100, 60, 5, 505, 600, 1'b1);
    for (int lv = 0; lv < 120; lv += 4) runOne(lv, "R6 endpoints", 1'b0);
    runOne(100, "R9 knee at max", 1'b0);
    chk("R9 knee at max", hiCount, 505);

    // Degenerate window gives pwm minimum (R7); zero period gives duty 0 (R9)
    setCfg(80, 80, 80, 80, 33, 700, 0, 1'b0);
    for (int lv = 0; lv < 200; lv += 25) begin
      runOne(lv, "R7 degenerate", 1'b0);
      chk("R9 zero period", duty, 0);
    end

    // Start while busy ignored (R10)
    setCfg(10, 50, 200, 100, 40, 900, 1000, 1'b0);
    runOne(30, "R10 busy start", 1'b1);
    runOne(150, "R10 busy start", 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule